// File: doc/BRIEF.md
# Dual-Side Process Queue Scheduler

This block keeps the program counters of every live process for two programs that compete in a shared circular memory. Each side owns a FIFO of counters. The machine takes turns between the sides, side 0 first, and each turn has two steps. First the fetch logic asks for a counter: the scheduler removes the head of the current side's queue and returns it. Then the execute logic reports what goes back into that side's queue. It can return nothing (the process halted), one address (the next counter or a taken branch target), or two ordered addresses (a split: the next counter, then the spawned one). The second address is kept only if the queue has room for it.

Before a battle starts, entry points are loaded into either queue through a load port. A start strobe then begins alternation. When a side's queue runs dry, the battle ends and the other side is reported as the winner. An optional limit on machine cycles ends an undecided battle as a draw. Every address that is stored is reduced modulo the memory size. That size is a parameter and need not be a power of two.

Top module: `duel_pc_sched`

## Requirements
- R1: While reset is held and in the cycle after it is released, `done`=0, `winner`=0, `pop_valid`=0 and `side_empty`=2'b11.
- R2: Before start, a `load_valid` cycle without `start` appends `load_addr` to the queue of side `load_side` (0 or 1). The load is ignored if that queue already holds DEPTH entries.
- R3: On `start` with both queues non-empty, the battle runs with side 0 first. If only side 0 is empty, the battle ends at once with `winner`=2. If only side 1 is empty, it ends with `winner`=1. If both are empty, it ends with `winner`=3.
- R4: While running, `pop_req` with no turn outstanding removes the head of the current side's queue. One cycle later, `pop_valid` pulses for one cycle with that address on `pop_addr`. Further `pop_req` cycles are refused until the push for that turn arrives.
- R5: Accepted pops alternate strictly between the sides: 0, 1, 0, 1, ... (`pop_side`).
- R6: A push with `push_kill`=1 appends nothing, so the popped process leaves its side.
- R7: A push with only `push_v0` set appends `push_a0` to the back of the queue of the side whose turn it is. Both the next counter and a taken branch target use this form. A push with only `push_v1` set appends `push_a1` in the same way.
- R8: A push with both `push_v0` and `push_v1` set appends `push_a0` and then `push_a1`, in that order. `push_a1` is dropped if the queue would hold more than DEPTH entries.
- R9: Every stored address, whether loaded or pushed, is reduced modulo CORE_SIZE.
- R10: If a push leaves the current side's queue empty, `done` rises in the next cycle and `winner` names the other side. The codes are 1 for side 0 winning, 2 for side 1 winning and 3 for a draw.
- R11: With `cycle_limit` non-zero, the push that completes side 1's turn in machine cycle number `cycle_limit` ends the battle with `winner`=3. A limit of 0 never ends the battle. A loss under R10 takes priority.
- R12: Once `done` is 1, it stays 1 with `winner` unchanged. From then on pops are refused and loads are ignored.
- R13: A push that arrives while no turn is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the battle (accepted only before start) |
| load_valid | input | 1 | Load an entry point |
| load_side | input | 1 | Side receiving the entry point |
| load_addr | input | AW | Entry point address |
| cycle_limit | input | CNT_W | Machine-cycle limit for a draw, 0 = none |
| pop_req | input | 1 | Fetch logic requests the next counter |
| pop_valid | output | 1 | One-cycle pulse: `pop_addr` and `pop_side` are valid |
| pop_side | output | 1 | Side of the issued counter |
| pop_addr | output | AW | Issued program counter |
| push_valid | input | 1 | Push transaction for the outstanding turn |
| push_kill | input | 1 | Halt: append nothing |
| push_v0 | input | 1 | First address valid |
| push_a0 | input | AW | First address |
| push_v1 | input | 1 | Second address valid |
| push_a1 | input | AW | Second address (the spawned process) |
| side_empty | output | 2 | Bit s is 1 when side s's queue is empty |
| done | output | 1 | Battle over |
| winner | output | 2 | 0 none, 1 side 0, 2 side 1, 3 draw |

## Verification
The assertions assume that the execute logic sends exactly one push for each issued counter, after `pop_valid`. They also assume that the execute logic never pushes while the fetch logic is being served in the same cycle. The pulse and alternation checks rely on this. The bench drives every turn through one task. That task raises `pop_req`, waits for the pulse, keeps the request up for one more cycle to test the refusal, and only then pushes. A stray push is sent deliberately only between turns, where R13 requires it to be ignored. DEPTH is kept a power of two, as the queue pointers require.

// File: rtl/duel_pkg.sv
package duel_pkg;
  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_SIDE0 = 2'd1,
    WIN_SIDE1 = 2'd2,
    WIN_DRAW  = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_OVER = 2'd2
  } phase_e;
endpackage

// File: rtl/duel_addr_wrap.sv
module duel_addr_wrap #(
  parameter int CORE_SIZE = 256,
  parameter int AW        = 8
) (
  input  logic [AW-1:0] raw,
  output logic [AW-1:0] wrapped
);
  // raw < 2**AW < 2*CORE_SIZE, so a single conditional subtraction suffices
  generate
    if (CORE_SIZE == (1 << AW)) begin : g_pow2
      assign wrapped = raw;
    end else begin : g_sub
      localparam logic [AW:0] SIZE_X = (AW+1)'(CORE_SIZE);
      logic [AW:0] diff;
      assign diff    = {1'b0, raw} - SIZE_X;
      assign wrapped = ({1'b0, raw} >= SIZE_X) ? diff[AW-1:0] : raw;
    end
  endgenerate
endmodule

// File: rtl/duel_pc_fifo.sv
module duel_pc_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr0_en,
  input  logic [AW-1:0] wr0_data,
  input  logic          wr1_en,
  input  logic [AW-1:0] wr1_data,
  input  logic          rd_en,
  output logic [AW-1:0] head,
  output logic [CW-1:0] count
);
  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW-1:0] wr1_ptr;

  // second entry lands behind the first when both are written
  assign wr1_ptr = wr0_en ? wp + PW'(1) : wp;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (wr0_en) mem[wp] <= wr0_data;
    if (wr1_en) mem[wr1_ptr] <= wr1_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp + PW'(wr0_en) + PW'(wr1_en);
      rp    <= rp + PW'(rd_en);
      count <= count + CW'(wr0_en) + CW'(wr1_en) - CW'(rd_en);
    end
  end
endmodule

// File: rtl/duel_turn_ctrl.sv
module duel_turn_ctrl
  import duel_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             load_valid,
  input  logic             load_side,
  input  logic             pop_req,
  input  logic             push_valid,
  input  logic             push_kill,
  input  logic             push_v0,
  input  logic             push_v1,
  input  logic [CNT_W-1:0] cycle_limit,
  input  logic [CW-1:0]    cnt0,
  input  logic [CW-1:0]    cnt1,
  output logic [1:0]       rd_en,
  output logic [1:0]       wr0_en,
  output logic [1:0]       wr1_en,
  output logic             sel_load,
  output logic             pop_fire,
  output logic             turn,
  output logic             pop_valid,
  output logic             pop_side,
  output logic             done,
  output logic [1:0]       winner
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  phase_e           phase;
  win_e             win_q;
  logic             pending;
  logic [CNT_W-1:0] cyc;
  logic [CNT_W-1:0] cyc_next;
  logic [CW-1:0]    cnt_turn, cnt_ld;
  logic             load_ok, push_fire, put0, put1, room1, lost, limit_hit;

  assign cnt_turn  = turn ? cnt1 : cnt0;
  assign cnt_ld    = load_side ? cnt1 : cnt0;
  assign sel_load  = (phase == PH_IDLE);
  assign load_ok   = sel_load && load_valid && !start && (cnt_ld < FULL);
  assign pop_fire  = (phase == PH_RUN) && pop_req && !pending;
  assign push_fire = (phase == PH_RUN) && push_valid && pending;
  assign room1     = push_v0 ? ((cnt_turn + CW'(1)) < FULL) : (cnt_turn < FULL);
  assign put0      = push_fire && !push_kill && push_v0;
  assign put1      = push_fire && !push_kill && push_v1 && room1;
  assign lost      = push_fire && (cnt_turn == '0) && !put0 && !put1;
  assign cyc_next  = cyc + CNT_W'(1);
  assign limit_hit = push_fire && turn && (cycle_limit != '0) && (cyc_next >= cycle_limit);

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      rd_en[s]  = pop_fire && (turn == s[0]);
      wr0_en[s] = (load_ok && (load_side == s[0])) || (put0 && (turn == s[0]));
      wr1_en[s] = put1 && (turn == s[0]);
    end
  end

  assign done   = (phase == PH_OVER);
  assign winner = win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      win_q     <= WIN_NONE;
      pending   <= 1'b0;
      turn      <= 1'b0;
      cyc       <= '0;
      pop_valid <= 1'b0;
      pop_side  <= 1'b0;
    end else begin
      pop_valid <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            if (cnt0 == '0 && cnt1 == '0) begin
              phase <= PH_OVER;
              win_q <= WIN_DRAW;
            end else if (cnt0 == '0) begin
              phase <= PH_OVER;
              win_q <= WIN_SIDE1;
            end else if (cnt1 == '0) begin
              phase <= PH_OVER;
              win_q <= WIN_SIDE0;
            end else begin
              phase <= PH_RUN;
              turn  <= 1'b0;
            end
          end
        end
        PH_RUN: begin
          if (pop_fire) begin
            pending   <= 1'b1;
            pop_valid <= 1'b1;
            pop_side  <= turn;
          end else if (push_fire) begin
            pending <= 1'b0;
            turn    <= ~turn;
            if (turn) cyc <= cyc_next;
            if (lost) begin
              phase <= PH_OVER;
              win_q <= turn ? WIN_SIDE0 : WIN_SIDE1;
            end else if (limit_hit) begin
              phase <= PH_OVER;
              win_q <= WIN_DRAW;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/duel_pc_sched.sv
module duel_pc_sched #(
  parameter int  CORE_SIZE = 256,
  parameter int  DEPTH     = 8,
  parameter int  CNT_W     = 16,
  localparam int AW        = $clog2(CORE_SIZE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             load_valid,
  input  logic             load_side,
  input  logic [AW-1:0]    load_addr,
  input  logic [CNT_W-1:0] cycle_limit,
  input  logic             pop_req,
  output logic             pop_valid,
  output logic             pop_side,
  output logic [AW-1:0]    pop_addr,
  input  logic             push_valid,
  input  logic             push_kill,
  input  logic             push_v0,
  input  logic [AW-1:0]    push_a0,
  input  logic             push_v1,
  input  logic [AW-1:0]    push_a1,
  output logic [1:0]       side_empty,
  output logic             done,
  output logic [1:0]       winner
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [AW-1:0] raw_addr  [3];
  logic [AW-1:0] wrap_addr [3];
  logic [AW-1:0] head      [2];
  logic [CW-1:0] cnt       [2];
  logic [1:0]    rd_en, wr0_en, wr1_en;
  logic          sel_load, pop_fire, turn;
  logic [AW-1:0] wr0_data;

  assign raw_addr[0] = load_addr;
  assign raw_addr[1] = push_a0;
  assign raw_addr[2] = push_a1;

  generate
    for (genvar g = 0; g < 3; g++) begin : g_wrap
      duel_addr_wrap #(.CORE_SIZE(CORE_SIZE), .AW(AW)) u_wrap (
        .raw     (raw_addr[g]),
        .wrapped (wrap_addr[g])
      );
    end
  endgenerate

  assign wr0_data = sel_load ? wrap_addr[0] : wrap_addr[1];

  generate
    for (genvar s = 0; s < 2; s++) begin : g_side
      duel_pc_fifo #(.DEPTH(DEPTH), .AW(AW)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr0_en   (wr0_en[s]),
        .wr0_data (wr0_data),
        .wr1_en   (wr1_en[s]),
        .wr1_data (wrap_addr[2]),
        .rd_en    (rd_en[s]),
        .head     (head[s]),
        .count    (cnt[s])
      );
      assign side_empty[s] = (cnt[s] == '0);
    end
  endgenerate

  duel_turn_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .load_valid  (load_valid),
    .load_side   (load_side),
    .pop_req     (pop_req),
    .push_valid  (push_valid),
    .push_kill   (push_kill),
    .push_v0     (push_v0),
    .push_v1     (push_v1),
    .cycle_limit (cycle_limit),
    .cnt0        (cnt[0]),
    .cnt1        (cnt[1]),
    .rd_en       (rd_en),
    .wr0_en      (wr0_en),
    .wr1_en      (wr1_en),
    .sel_load    (sel_load),
    .pop_fire    (pop_fire),
    .turn        (turn),
    .pop_valid   (pop_valid),
    .pop_side    (pop_side),
    .done        (done),
    .winner      (winner)
  );

  always_ff @(posedge clk) begin
    if (rst) pop_addr <= '0;
    else if (pop_fire) pop_addr <= head[turn];
  end
endmodule

// File: rtl/duel_pc_sched_chk.sv
module duel_pc_sched_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          pop_valid,
  input logic          pop_side,
  input logic          done,
  input logic [1:0]    winner,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1
);
  logic seen, last_side;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= 1'b0;
      last_side <= 1'b0;
    end else if (pop_valid) begin
      seen      <= 1'b1;
      last_side <= pop_side;
    end
  end

  // R4
  pop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pop_valid |=> !pop_valid);

  // R5
  side_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_valid && seen) |-> (pop_side != last_side));

  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(winner)));

  // R12
  done_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !pop_valid);

  // R10
  winner_done_chk: assert property (@(posedge clk) disable iff (rst)
    done == (winner != 2'd0));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt0 <= CW'(DEPTH)) && (cnt1 <= CW'(DEPTH)));
endmodule

bind duel_pc_sched duel_pc_sched_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pop_valid (pop_valid),
  .pop_side  (pop_side),
  .done      (done),
  .winner    (winner),
  .cnt0      (cnt[0]),
  .cnt1      (cnt[1])
);

// File: tb/duel_pc_sched_bench.sv
module duel_pc_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CSIZE      = 200;
  localparam int QD         = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, load_valid = 1'b0, load_side = 1'b0;
  logic [7:0] load_addr = '0;
  logic [7:0] cycle_limit = '0;
  logic       pop_req = 1'b0;
  logic       pop_valid, pop_side;
  logic [7:0] pop_addr;
  logic       push_valid = 1'b0, push_kill = 1'b0, push_v0 = 1'b0, push_v1 = 1'b0;
  logic [7:0] push_a0 = '0, push_a1 = '0;
  logic [1:0] side_empty;
  logic       done;
  logic [1:0] winner;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] mq0[$];
  logic [7:0] mq1[$];
  bit         exp_side[$];
  logic [7:0] exp_addr[$];
  string      exp_tag[$];
  bit         idle_m;
  bit         bturn;
  int         bcyc;
  int         blim;

  always #(CLK_PERIOD/2) clk = ~clk;

  duel_pc_sched #(.CORE_SIZE(CSIZE), .DEPTH(QD), .CNT_W(8)) u_duel_pc_sched (
    .clk(clk), .rst(rst), .start(start), .load_valid(load_valid),
    .load_side(load_side), .load_addr(load_addr), .cycle_limit(cycle_limit),
    .pop_req(pop_req), .pop_valid(pop_valid), .pop_side(pop_side),
    .pop_addr(pop_addr), .push_valid(push_valid), .push_kill(push_kill),
    .push_v0(push_v0), .push_a0(push_a0), .push_v1(push_v1), .push_a1(push_a1),
    .side_empty(side_empty), .done(done), .winner(winner)
  );

  function automatic logic [7:0] wrapb(input logic [7:0] a);
    return (a >= 8'(CSIZE)) ? a - 8'(CSIZE) : a;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  // monitor: compare every issued counter with the scoreboard
  always @(negedge clk) begin
    if (!rst && pop_valid) begin
      if (exp_addr.size() == 0) begin
        chk(1'b0, "R4 unexpected pop", int'(pop_addr), -1);
      end else begin
        automatic bit         es = exp_side.pop_front();
        automatic logic [7:0] ea = exp_addr.pop_front();
        automatic string      et = exp_tag.pop_front();
        chk(pop_side == es, {"R5 side ", et}, int'(pop_side), int'(es));
        chk(pop_addr == ea, {"addr ", et}, int'(pop_addr), int'(ea));
      end
    end
  end

  task automatic do_reset;
    rst = 1'b1;
    mq0.delete(); mq1.delete();
    exp_side.delete(); exp_addr.delete(); exp_tag.delete();
    idle_m = 1'b1; bturn = 1'b0; bcyc = 0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic do_load(input bit s, input logic [7:0] a);
    load_valid = 1'b1; load_side = s; load_addr = a;
    tick();
    load_valid = 1'b0;
    if (idle_m) begin
      if (s == 1'b0 && mq0.size() < QD) mq0.push_back(wrapb(a));
      if (s == 1'b1 && mq1.size() < QD) mq1.push_back(wrapb(a));
    end
  endtask

  task automatic do_start;
    start = 1'b1;
    tick();
    start = 1'b0;
    idle_m = 1'b0;
  endtask

  task automatic do_turn(input bit kill, input bit v0, input logic [7:0] a0,
                         input bit v1, input logic [7:0] a1, input string tag);
    automatic bit s = bturn;
    automatic int sz;
    automatic int ew;
    exp_side.push_back(s);
    exp_addr.push_back(s ? mq1.pop_front() : mq0.pop_front());
    exp_tag.push_back(tag);
    pop_req = 1'b1;
    tick();
    chk(pop_valid == 1'b1, "R4 pop issued", int'(pop_valid), 1);
    tick();
    chk(pop_valid == 1'b0, "R4 pop refused while pending", int'(pop_valid), 0);
    pop_req = 1'b0;
    push_valid = 1'b1; push_kill = kill; push_v0 = v0; push_a0 = a0;
    push_v1 = v1; push_a1 = a1;
    tick();
    push_valid = 1'b0; push_kill = 1'b0; push_v0 = 1'b0; push_v1 = 1'b0;
    if (!kill) begin
      if (s == 1'b0) begin
        if (v0) mq0.push_back(wrapb(a0));
        if (v1 && mq0.size() < QD) mq0.push_back(wrapb(a1));
      end else begin
        if (v0) mq1.push_back(wrapb(a0));
        if (v1 && mq1.size() < QD) mq1.push_back(wrapb(a1));
      end
    end
    bturn = ~bturn;
    if (s) bcyc++;
    sz = s ? mq1.size() : mq0.size();
    ew = 0;
    if (sz == 0) ew = s ? 1 : 2;
    else if (s && blim != 0 && bcyc >= blim) ew = 3;
    chk(done == (ew != 0), (ew == 3) ? "R11 done" : "R10 done", int'(done), int'(ew != 0));
    chk(int'(winner) == ew, (ew == 3) ? "R11 winner" : "R10 winner", int'(winner), ew);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // ---- battle with a loss ----
    blim = 0; cycle_limit = 8'd0;
    do_reset();
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(winner == 2'd0, "R1 winner", int'(winner), 0);
    chk(pop_valid == 1'b0, "R1 pop_valid", int'(pop_valid), 0);
    chk(side_empty == 2'b11, "R1 side_empty", int'(side_empty), 3);
    do_load(1'b0, 8'd10);
    do_load(1'b0, 8'd20);
    do_load(1'b1, 8'd230);          // R9 load wraps to 30
    do_load(1'b1, 8'd40);
    do_load(1'b1, 8'd41);
    do_load(1'b1, 8'd42);
    do_load(1'b1, 8'd43);           // R2 queue full: ignored
    chk(side_empty == 2'b00, "R2 loaded", int'(side_empty), 0);
    do_start();
    chk(done == 1'b0, "R3 running", int'(done), 0);
    do_turn(1'b0, 1'b1, 8'd11, 1'b0, 8'd0,  "R7 single");
    do_turn(1'b0, 1'b1, 8'd31, 1'b1, 8'd99, "R8 split dropped when full");
    do_turn(1'b0, 1'b1, 8'd21, 1'b1, 8'd250, "R8 R9 split order and wrap");
    do_turn(1'b1, 1'b0, 8'd0,  1'b0, 8'd0,  "R6 halt");
    // R13 stray push between turns must be ignored
    push_valid = 1'b1; push_v0 = 1'b1; push_a0 = 8'd77;
    tick();
    push_valid = 1'b0; push_v0 = 1'b0;
    chk(pop_valid == 1'b0, "R13 stray push", int'(pop_valid), 0);
    do_turn(1'b1, 1'b0, 8'd0,  1'b0, 8'd0,  "R13 R6 halt");
    do_turn(1'b0, 1'b1, 8'd230, 1'b0, 8'd0, "R9 push wrap");
    do_turn(1'b1, 1'b0, 8'd0,  1'b0, 8'd0,  "R8 order first");
    do_turn(1'b0, 1'b0, 8'd0,  1'b1, 8'd43, "R7 second only");
    do_turn(1'b1, 1'b0, 8'd0,  1'b0, 8'd0,  "R10 last process halts");
    // R12 after done
    pop_req = 1'b1;
    repeat (3) begin
      tick();
      chk(pop_valid == 1'b0, "R12 pop refused", int'(pop_valid), 0);
    end
    pop_req = 1'b0;
    do_load(1'b0, 8'd5);
    chk(side_empty[0] == 1'b1, "R12 load ignored", int'(side_empty[0]), 1);
    chk(winner == 2'd2, "R12 winner held", int'(winner), 2);
    chk(exp_addr.size() == 0, "R4 all pops seen", exp_addr.size(), 0);

    // ---- draw on cycle limit ----
    blim = 3; cycle_limit = 8'd3;
    do_reset();
    do_load(1'b0, 8'd100);
    do_load(1'b1, 8'd150);
    do_start();
    for (int k = 0; k < 3; k++) begin
      do_turn(1'b0, 1'b1, 8'(101 + k), 1'b0, 8'd0, "R11 side0");
      do_turn(1'b0, 1'b1, 8'(151 + k), 1'b0, 8'd0, "R11 side1");
    end

    // ---- start with one side empty ----
    blim = 0; cycle_limit = 8'd0;
    do_reset();
    do_load(1'b0, 8'd7);
    do_start();
    chk(done == 1'b1, "R3 empty side1 done", int'(done), 1);
    chk(winner == 2'd1, "R3 empty side1 winner", int'(winner), 1);

    // ---- start with both sides empty ----
    do_reset();
    do_start();
    chk(winner == 2'd3, "R3 both empty draw", int'(winner), 3);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule